// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a register-mapped watchdog for a simple 32-bit bus made of an address, a write strobe, write data and read data. A down-counter runs from a programmable reload value. On its first pass through zero it sets a pending interrupt and starts again from the reload value. If the pending interrupt has not been acknowledged by the time the count passes through zero a second time, the block drives a sticky system-reset request. Software keeps the system alive by writing the acknowledge register. Each write reloads the counter and clears the pending interrupt.

Every register except the lock register ignores writes until the lock register holds the 32-bit key 0x1ACCE551. Any other value written there closes the lock again. Reads always work. The read data is registered, so it returns the selected register one clock after the address is presented.

Top module: `wdt_twostage`

## Requirements
- R1: After the synchronous reset, the block reads as follows: lock (0xC00) reads 1, control (0x008) reads 0, load (0x000) and current value (0x004) read 0xFFFFFFFF, raw (0x010) and masked (0x014) status read 0, and irq_o and sys_rst_o are low.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks the block, and the lock register then reads 0. Writing any other value to 0xC00 locks it, and it then reads 1. The lock register accepts writes in either state.
- R3: While the block is locked, writes to load, control and acknowledge (0x00C) have no effect.
- R4: A write to load stores the value, and the current value register equals it from the next clock on. A written 0 is stored as 1.
- R5: While control bit 0 is 1, the count drops by one per clock. While control bit 0 is 0, the count holds.
- R6: With control bit 0 set and the interrupt clear, starting from count C, raw status bit 0 sets C+1 clocks later, and the count restarts from the load value.
- R7: Raw status bit 0 shows the pending interrupt whatever the control bits are. Masked status bit 0 and irq_o both equal raw AND control bit 0.
- R8: A write of any value to 0x00C clears the pending interrupt and reloads the count from load.
- R9: With control bits 0 and 1 set, an expiry while the interrupt is still pending raises sys_rst_o. From an acknowledge with load L and no further acknowledge, that takes 2L+2 clocks. With control bit 1 clear, sys_rst_o never rises.
- R10: Once high, sys_rst_o stays high until the block's own reset, whatever is written.
- R11: rd_data holds the register selected by addr as it stood at the previous clock edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, masked pending state |
| sys_rst_o | output | 1 | Sticky system-reset request |

## Verification
The bench times the interrupt from the enabling write and the reset from the last acknowledge. An off-by-one in expiry detection or in the reload would move either edge by a clock. It writes load 0 and load 1 to catch a design that does not clamp, or that stalls or wraps at the minimum. Writes while locked, including a locked acknowledge, would change readable state in a design with a leaky lock. The bench also clears control bit 1 and writes to the block after a reset request. A design that raises reset without that enable, or that lets the request drop, would show it on sys_rst_o.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [11:0] OFF_LOAD  = 12'h000;
  localparam logic [11:0] OFF_VALUE = 12'h004;
  localparam logic [11:0] OFF_CTRL  = 12'h008;
  localparam logic [11:0] OFF_ACK   = 12'h00C;
  localparam logic [11:0] OFF_RAW   = 12'h010;
  localparam logic [11:0] OFF_MSK   = 12'h014;
  localparam logic [11:0] OFF_LOCK  = 12'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic cnt_en;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic              lock_q,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic              reload_p,
  output logic              ack_p,
  output logic [CNT_W-1:0]  reload_val
);
  logic             open_wr;
  logic [CNT_W-1:0] wr_load;

  assign open_wr  = wr_en && !lock_q;
  assign wr_load  = (wr_data[CNT_W-1:0] == '0) ? CNT_W'(1) : wr_data[CNT_W-1:0];
  assign reload_p = open_wr && (addr == ADDR_W'(OFF_LOAD));
  assign ack_p    = open_wr && (addr == ADDR_W'(OFF_ACK));
  assign reload_val = reload_p ? wr_load : load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b1;
      ctrl_q <= '0;
      load_q <= LOAD_RESET;
    end else begin
      if (wr_en && addr == ADDR_W'(OFF_LOCK))
        lock_q <= (wr_data != UNLOCK_KEY);
      if (open_wr && addr == ADDR_W'(OFF_CTRL))
        ctrl_q <= ctrl_t'(wr_data[1:0]);
      if (reload_p)
        load_q <= wr_load;
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RESET = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             rst_en,
  input  logic             reload_p,
  input  logic             ack_p,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             raw_q,
  output logic             sys_rst_q
);
  logic expire;
  assign expire = cnt_en && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= LOAD_RESET;
      raw_q     <= 1'b0;
      sys_rst_q <= 1'b0;
    end else begin
      if (reload_p || ack_p) begin
        count_q <= reload_val;
        if (ack_p) raw_q <= 1'b0;
      end else if (expire) begin
        count_q <= reload_val;
        raw_q   <= 1'b1;
        if (raw_q && rst_en) sys_rst_q <= 1'b1;
      end else if (cnt_en) begin
        count_q <= count_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic             lock_q;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_val;
  logic             reload_p;
  logic             ack_p;
  logic             raw_q;
  logic [31:0]      rd_mux;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOAD_RESET(LOAD_RESET)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .lock_q(lock_q), .ctrl_q(ctrl_q), .load_q(load_q),
    .reload_p(reload_p), .ack_p(ack_p), .reload_val(reload_val)
  );

  wdt_core #(.CNT_W(CNT_W), .LOAD_RESET(LOAD_RESET)) u_core (
    .clk(clk), .rst(rst), .cnt_en(ctrl_q.cnt_en), .rst_en(ctrl_q.rst_en),
    .reload_p(reload_p), .ack_p(ack_p), .reload_val(reload_val),
    .count_q(count_q), .raw_q(raw_q), .sys_rst_q(sys_rst_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      ADDR_W'(OFF_LOAD):  rd_mux = 32'(load_q);
      ADDR_W'(OFF_VALUE): rd_mux = 32'(count_q);
      ADDR_W'(OFF_CTRL):  rd_mux = {30'd0, ctrl_q};
      ADDR_W'(OFF_RAW):   rd_mux = {31'd0, raw_q};
      ADDR_W'(OFF_MSK):   rd_mux = {31'd0, raw_q & ctrl_q.cnt_en};
      ADDR_W'(OFF_LOCK):  rd_mux = {31'd0, lock_q};
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign irq_o = raw_q & ctrl_q.cnt_en;
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              lock_q,
  input logic [1:0]        ctrl_q,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  count_q,
  input logic              raw_q,
  input logic              sys_rst_o
);
  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_q && wr_en && addr != ADDR_W'(OFF_LOCK)) |=>
      ($stable(ctrl_q) && $stable(load_q) && (raw_q || !$past(raw_q))));

  assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    load_q != '0);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && count_q != '0 && !wr_en) |=> (count_q == $past(count_q) - 1'b1));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !wr_en) |=> $stable(count_q));

  assert_raw_only_on_expiry_R6: assert property (@(posedge clk) disable iff (rst)
    (!raw_q && !(ctrl_q[0] && count_q == '0)) |=> !raw_q);

  assert_reset_needs_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_o && !(raw_q && ctrl_q == 2'b11 && count_q == '0)) |=> !sys_rst_o);

  assert_reset_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> sys_rst_o);
endmodule

bind wdt_twostage wdt_twostage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .lock_q(lock_q),
  .ctrl_q(ctrl_q), .load_q(load_q), .count_q(count_q), .raw_q(raw_q),
  .sys_rst_o(sys_rst_o)
);

// File: tb/tb_wdt_twostage.sv
module tb_wdt_twostage;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
    A_ACK = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014, A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq_o, sys_rst_o;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_twostage dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .sys_rst_o(sys_rst_o));

  function automatic logic [31:0] clamp(input logic [31:0] v);
    return (v == 0) ? 32'd1 : v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_edge(input bit on_rst, output int n);
    n = 0;
    while (((on_rst ? sys_rst_o : irq_o) !== 1'b1) && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, v;
    int n, L;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(A_LOCK, d); check("R1 lock", d, 1);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_LOAD, d); check("R1 load", d, 32'hFFFFFFFF);
    rd(A_VAL, d);  check("R1 value", d, 32'hFFFFFFFF);
    rd(A_RAW, d);  check("R1 raw", d, 0);
    rd(A_MSK, d);  check("R1 masked", d, 0);
    check("R1 irq", irq_o, 0); check("R1 sysrst", sys_rst_o, 0);
    rd(12'h020, d); check("R11 unmapped", d, 0);
    // R3 locked writes
    wr(A_CTRL, 3); wr(A_LOAD, 32'h55);
    rd(A_CTRL, d); check("R3 ctrl locked", d, 0);
    rd(A_LOAD, d); check("R3 load locked", d, 32'hFFFFFFFF);
    // R2 lock key
    wr(A_LOCK, KEY); rd(A_LOCK, d); check("R2 unlock", d, 0);
    wr(A_LOCK, 32'h1); rd(A_LOCK, d); check("R2 relock", d, 1);
    wr(A_LOCK, KEY ^ 32'h100); rd(A_LOCK, d); check("R2 near key", d, 1);
    wr(A_LOCK, KEY);
    // R4 load writes incl. zero
    wr(A_LOAD, 0); rd(A_LOAD, d); check("R4 zero clamp", d, 1);
    rd(A_VAL, d); check("R4 value follows", d, 1);
    for (int i = 0; i < 16; i++) begin
      v = (i == 0) ? 32'hFFFFFFFF : $urandom;
      wr(A_LOAD, v);
      rd(A_LOAD, d); check("R4 load readback", d, clamp(v));
      rd(A_VAL, d);  check("R4 value readback", d, clamp(v));
    end
    // R5 counting step and hold
    wr(A_LOAD, 1000); wr(A_CTRL, 1);
    rd(A_VAL, d); rd(A_VAL, d2); check("R5 step", d - d2, 1);
    check("R11 value tracks", d2 < 1000 ? 1 : 0, 1);
    wr(A_CTRL, 0);
    rd(A_VAL, d); repeat (5) @(negedge clk); rd(A_VAL, d2); check("R5 hold", d2, d);
    // R6/R7 first expiry, random loads including minimum
    for (int i = 0; i < 12; i++) begin
      L = (i == 0) ? 1 : 1 + int'($urandom % 20);
      wr(A_LOAD, L); wr(A_ACK, $urandom); wr(A_CTRL, 1);
      wait_edge(0, n); check("R6 irq latency", n, L + 1);
      rd(A_RAW, d); check("R7 raw set", d, 1);
      rd(A_MSK, d); check("R7 masked set", d, 1);
      wr(A_CTRL, 0);
      rd(A_MSK, d); check("R7 masked off", d, 0);
      rd(A_RAW, d); check("R7 raw kept", d, 1);
      check("R7 irq off", irq_o, 0);
    end
    // R3 locked acknowledge ignored
    wr(A_LOCK, 32'h0); wr(A_ACK, 32'h1);
    rd(A_RAW, d); check("R3 ack locked", d, 1);
    wr(A_LOCK, KEY);
    // R8 acknowledge clears and reloads
    wr(A_LOAD, 10); wr(A_CTRL, 0);
    wr(A_ACK, 32'hDEAD);
    rd(A_RAW, d); check("R8 raw cleared", d, 0);
    rd(A_VAL, d); check("R8 reload", d, 10);
    // R9 without reset enable: no reset
    wr(A_CTRL, 1);
    repeat (60) @(negedge clk);
    check("R9 no rst_en", sys_rst_o, 0);
    check("R7 irq on", irq_o, 1);
    // R9 keepalive then timeout
    wr(A_CTRL, 0); wr(A_ACK, 0); wr(A_CTRL, 3);
    d = 0;
    for (int k = 0; k < 8; k++) begin
      repeat (5) begin @(negedge clk); d = d | {30'd0, sys_rst_o, irq_o}; end
      wr(A_ACK, $urandom);
    end
    check("R8 keepalive", d, 0);
    wait_edge(1, n); check("R9 reset latency", n, 22);
    // R10 sticky
    wr(A_ACK, 0); wr(A_CTRL, 0); wr(A_LOAD, 5);
    repeat (20) @(negedge clk);
    check("R10 sticky", sys_rst_o, 1);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check("R10 cleared by rst", sys_rst_o, 0);
    rd(A_LOCK, d); check("R1 relocked", d, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule